// File: doc/BRIEF.md
# Windowed Register Access Bridge

The bridge sits between a host-side requester and a narrow memory-mapped aperture. The aperture covers 1 MB, but the device behind it spans 32 MB. The requester issues one 32-bit read or write at a time, carrying a flat byte offset into the 32 MB space. The bridge turns each request into one or more single-word transactions on the aperture port.

Offsets in the lower 512 KB pass straight through to the same aperture address. Larger offsets are reached through the upper half of the aperture:

- The bridge writes a window number, tagged with an enable flag, into a window-select register.
- It reads that register back and compares the value with what it wrote.
- It then performs the data access in the upper half of the aperture.

The bridge remembers the last window it programmed, so consecutive accesses to the same window skip both the register write and its readback. A parameter can turn this caching off. A configuration input can disable windowing altogether.

Top module: `win_reg_bridge`

## Requirements
- R1: After reset, `req_ready` is 1, and `ap_valid`, `rsp_done` and `win_err` are 0. No window counts as programmed, so the first windowed access always writes the window-select register.
- R2: With windowing enabled, an offset below 0x80000 produces exactly one aperture transaction at the same address, with no window programming.
- R3: With `win_en` low, every offset produces exactly one aperture transaction at the offset's low 20 bits.
- R4: A windowed access that programs the window issues three transactions, in this order. First, a write to aperture address 0x310C of the value (enable flag OR offset[24:19]). Second, a read of 0x310C. Third, the data access at 0x80000 OR offset[18:0].
- R5: The enable flag is bit `EN_BIT` of the select value: bit 30 by default (0x40000000), or bit 31 (0x80000000) when `EN_BIT` is 31.
- R6: With `FORCE_REPROG` = 0, a windowed access whose window equals the last programmed window issues only the data transaction.
- R7: With `FORCE_REPROG` = 1, every windowed access programs and reads back the window register, even if the window is unchanged.
- R8: If the readback value differs from the value written, `win_err` pulses high for exactly one cycle and the data access still completes. A matching readback raises no pulse.
- R9: Only one request is outstanding at a time. `req_ready` falls in the cycle after acceptance and stays low until the access completes. Completion is a one-cycle `rsp_done` pulse, and for a read the data is on `rsp_rdata` in that same cycle.
- R10: Each aperture transaction holds `ap_valid`, `ap_addr`, `ap_write` and `ap_wdata` stable until `ap_ready` is seen. A window-select write is followed at once by its readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_en | input | 1 | Windowing enable; when low, all offsets go direct |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | Flat byte offset into the device space |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_done` |
| win_err | output | 1 | One-cycle pulse on a window readback mismatch |
| ap_valid | output | 1 | Aperture transaction request |
| ap_ready | input | 1 | Aperture accepts the transaction; read data valid in the same cycle |
| ap_write | output | 1 | Aperture transaction is a write |
| ap_addr | output | 20 | Aperture byte address |
| ap_wdata | output | 32 | Aperture write data |
| ap_rdata | input | 32 | Aperture read data |

## Verification
The bench runs two instances side by side on the same request stream:

- One uses the defaults: enable flag at bit 30, window caching on.
- The other sets `EN_BIT` = 31 and `FORCE_REPROG` = 1.

This pairing exposes both enable-flag encodings and both programming policies on identical traffic. For example, a repeated window costs one transaction in the first instance and three in the second.

The aperture model for the default instance can corrupt the readback and can stall `ap_ready` on alternate cycles. These two features bring the mismatch pulse and the hold-until-ready behaviour within reach.

// File: rtl/win_reg_bridge.sv
module win_reg_bridge #(
  parameter int OFF_W = 25,
  parameter int AP_W = 20,
  parameter int WIN_SHIFT = 19,
  parameter int EN_BIT = 30,
  parameter int FORCE_REPROG = 0,
  parameter logic [19:0] SEL_ADDR = 20'h0310C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [24:0]      req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_done,
  output logic [31:0]      rsp_rdata,
  output logic             win_err,
  output logic             ap_valid,
  input  logic             ap_ready,
  output logic             ap_write,
  output logic [19:0]      ap_addr,
  output logic [31:0]      ap_wdata,
  input  logic [31:0]      ap_rdata
);
  localparam int WIN_W = OFF_W - WIN_SHIFT;
  localparam logic [OFF_W-1:0] WIN_LIMIT = OFF_W'(1) << WIN_SHIFT;
  localparam logic [AP_W-1:0] WIN_BASE = AP_W'(1) << WIN_SHIFT;
  localparam logic [31:0] EN_MASK = 32'd1 << EN_BIT;

  typedef enum logic [2:0] {S_IDLE, S_WR_WIN, S_RD_WIN, S_CHECK, S_DATA, S_DONE} state_t;
  state_t state;

  logic [OFF_W-1:0] cur_addr;
  logic             cur_wr;
  logic [31:0]      cur_wdata;
  logic             direct_q;
  logic [WIN_W-1:0] cache_win;
  logic             cache_ok;
  logic [31:0]      rb_q;
  logic [31:0]      rdata_q;

  wire [WIN_W-1:0] req_win = req_addr[WIN_SHIFT +: WIN_W];
  wire [WIN_W-1:0] cur_win = cur_addr[WIN_SHIFT +: WIN_W];
  wire req_direct = !win_en || (req_addr < WIN_LIMIT);
  wire cache_hit = (FORCE_REPROG == 0) && cache_ok && (cache_win == req_win);
  wire [31:0] sel_val = EN_MASK | 32'(cur_win);
  wire [AP_W-1:0] data_addr = direct_q ? cur_addr[AP_W-1:0]
                                       : (WIN_BASE | AP_W'(cur_addr[WIN_SHIFT-1:0]));
  wire xfer = ap_valid && ap_ready;

  assign req_ready = (state == S_IDLE);
  assign ap_valid  = (state == S_WR_WIN) || (state == S_RD_WIN) || (state == S_DATA);
  assign ap_write  = (state == S_WR_WIN) || ((state == S_DATA) && cur_wr);
  assign ap_addr   = (state == S_DATA) ? data_addr : SEL_ADDR;
  assign ap_wdata  = (state == S_WR_WIN) ? sel_val : cur_wdata;
  assign win_err   = (state == S_CHECK) && (rb_q != sel_val);
  assign rsp_done  = (state == S_DONE);
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_addr  <= '0;
      cur_wr    <= 1'b0;
      cur_wdata <= '0;
      direct_q  <= 1'b0;
      cache_win <= '0;
      cache_ok  <= 1'b0;
      rb_q      <= '0;
      rdata_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          cur_addr  <= req_addr;
          cur_wr    <= req_write;
          cur_wdata <= req_wdata;
          direct_q  <= req_direct;
          state     <= (req_direct || cache_hit) ? S_DATA : S_WR_WIN;
        end
        S_WR_WIN: if (xfer) begin
          cache_win <= cur_win;
          cache_ok  <= 1'b1;
          state     <= S_RD_WIN;
        end
        S_RD_WIN: if (xfer) begin
          rb_q  <= ap_rdata;
          state <= S_CHECK;
        end
        S_CHECK: state <= S_DATA;
        S_DATA: if (xfer) begin
          if (!cur_wr) rdata_q <= ap_rdata;
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/win_reg_bridge_chk.sv
module win_reg_bridge_chk #(
  parameter logic [19:0] SEL_ADDR = 20'h0310C
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_done,
  input logic        win_err,
  input logic        ap_valid,
  input logic        ap_ready,
  input logic        ap_write,
  input logic [19:0] ap_addr,
  input logic [31:0] ap_wdata
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ap_valid);

  p_readback_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid && ap_ready && ap_write && ap_addr == SEL_ADDR)
      |=> (ap_valid && !ap_write && ap_addr == SEL_ADDR));

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_err |=> !win_err);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_done_after_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_done) |-> $past(ap_valid && ap_ready));

  p_hold_until_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid && !ap_ready)
      |=> (ap_valid && $stable(ap_addr) && $stable(ap_write) && $stable(ap_wdata)));
endmodule

bind win_reg_bridge win_reg_bridge_chk #(.SEL_ADDR(SEL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .win_err(win_err), .ap_valid(ap_valid), .ap_ready(ap_ready),
  .ap_write(ap_write), .ap_addr(ap_addr), .ap_wdata(ap_wdata)
);

// File: tb/win_reg_bridge_bench.sv
module win_reg_bridge_bench;
  localparam logic [19:0] SEL = 20'h0310C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        win_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [24:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        stall = 1'b0;
  logic        corrupt = 1'b0;

  logic        req_ready, rsp_done, win_err, ap_valid, ap_write;
  logic [31:0] rsp_rdata, ap_wdata, ap_rdata;
  logic [19:0] ap_addr;
  logic        ap_ready = 1'b0;
  logic [31:0] sel_reg = '0;

  logic        req_ready2, rsp_done2, win_err2, ap_valid2, ap_write2;
  logic [31:0] rsp_rdata2, ap_wdata2, ap_rdata2;
  logic [19:0] ap_addr2;
  logic [31:0] sel_reg2 = '0;

  win_reg_bridge u_win_reg_bridge (
    .clk(clk), .rst_n(rst_n), .win_en(win_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .win_err(win_err),
    .ap_valid(ap_valid), .ap_ready(ap_ready), .ap_write(ap_write),
    .ap_addr(ap_addr), .ap_wdata(ap_wdata), .ap_rdata(ap_rdata));

  win_reg_bridge #(.EN_BIT(31), .FORCE_REPROG(1)) u_win_reg_bridge_force (
    .clk(clk), .rst_n(rst_n), .win_en(win_en),
    .req_valid(req_valid), .req_ready(req_ready2), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done2), .rsp_rdata(rsp_rdata2), .win_err(win_err2),
    .ap_valid(ap_valid2), .ap_ready(1'b1), .ap_write(ap_write2),
    .ap_addr(ap_addr2), .ap_wdata(ap_wdata2), .ap_rdata(ap_rdata2));

  assign ap_rdata  = (ap_addr == SEL) ? (sel_reg ^ {31'd0, corrupt}) : {12'hD00, ap_addr};
  assign ap_rdata2 = (ap_addr2 == SEL) ? sel_reg2 : {12'hD00, ap_addr2};

  always @(negedge clk) ap_ready <= stall ? ~ap_ready : 1'b1;

  logic [19:0] lg_addr [0:15];
  logic        lg_wr   [0:15];
  logic [31:0] lg_wd   [0:15];
  int nlog = 0, nlog2 = 0, ndone = 0, ndone2 = 0, nerr = 0, nerr2 = 0;
  logic [31:0] last_rd = '0;

  always @(posedge clk) begin
    if (ap_valid && ap_ready) begin
      lg_addr[nlog % 16] <= ap_addr;
      lg_wr[nlog % 16]   <= ap_write;
      lg_wd[nlog % 16]   <= ap_wdata;
      nlog <= nlog + 1;
      if (ap_write && ap_addr == SEL) sel_reg <= ap_wdata;
    end
    if (ap_valid2) begin
      nlog2 <= nlog2 + 1;
      if (ap_write2 && ap_addr2 == SEL) sel_reg2 <= ap_wdata2;
    end
    if (rsp_done) begin ndone <= ndone + 1; last_rd <= rsp_rdata; end
    if (rsp_done2) ndone2 <= ndone2 + 1;
    if (win_err) nerr <= nerr + 1;
    if (win_err2) nerr2 <= nerr2 + 1;
  end

  int tests = 0, fails = 0;
  int b1, be;
  logic busy_seen;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [24:0] off, input logic [31:0] wd);
    int d1, d2;
    b1 = nlog; be = nerr; d1 = ndone; d2 = ndone2;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = off; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = !req_ready;
    while (ndone == d1 || ndone2 == d2) @(negedge clk);
  endtask

  task automatic chk_entry(input string req, input int k, input logic [19:0] a,
                           input logic w, input logic [31:0] d, input logic chk_d);
    chk(req, 32'(lg_addr[(b1 + k) % 16]), 32'(a));
    chk(req, 32'(lg_wr[(b1 + k) % 16]), 32'(w));
    if (chk_d) chk(req, lg_wd[(b1 + k) % 16], d);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 ap_valid", 32'(ap_valid), 32'd0);
    chk("R1 rsp_done", 32'(rsp_done), 32'd0);
    chk("R1 win_err", 32'(win_err), 32'd0);
  endtask

  task automatic t_direct_read;
    do_req(1'b0, 25'h0001234, '0);
    chk("R2 count", 32'(nlog - b1), 32'd1);
    chk_entry("R2 entry", 0, 20'h01234, 1'b0, '0, 1'b0);
    chk("R2 rdata", last_rd, 32'hD0001234);
    chk("R9 busy", 32'(busy_seen), 32'd1);
  endtask

  task automatic t_boundary_low;
    do_req(1'b1, 25'h007FFFC, 32'h1111_2222);
    chk("R2 edge count", 32'(nlog - b1), 32'd1);
    chk_entry("R2 edge entry", 0, 20'h7FFFC, 1'b1, 32'h1111_2222, 1'b1);
  endtask

  task automatic t_first_window;
    int c2;
    c2 = nlog2;
    do_req(1'b1, 25'h0080010, 32'hCAFE_0001);
    chk("R1 R4 count", 32'(nlog - b1), 32'd3);
    chk_entry("R4 R5 sel write", 0, SEL, 1'b1, 32'h4000_0001, 1'b1);
    chk_entry("R4 readback", 1, SEL, 1'b0, '0, 1'b0);
    chk_entry("R4 data", 2, 20'h80010, 1'b1, 32'hCAFE_0001, 1'b1);
    chk("R8 no err", 32'(nerr - be), 32'd0);
    chk("R5 bit31 select", sel_reg2, 32'h8000_0001);
    chk("R7 forced count", 32'(nlog2 - c2), 32'd3);
  endtask

  task automatic t_cached;
    int c2;
    c2 = nlog2;
    do_req(1'b0, 25'h00FFFF0, '0);
    chk("R6 cached count", 32'(nlog - b1), 32'd1);
    chk_entry("R6 data", 0, 20'hFFFF0, 1'b0, '0, 1'b0);
    chk("R6 rdata", last_rd, 32'hD00FFFF0);
    chk("R7 reprogram count", 32'(nlog2 - c2), 32'd3);
  endtask

  task automatic t_top_window;
    do_req(1'b0, 25'h1FFFFFC, '0);
    chk("R4 top count", 32'(nlog - b1), 32'd3);
    chk_entry("R4 top sel", 0, SEL, 1'b1, 32'h4000_003F, 1'b1);
    chk_entry("R4 top data", 2, 20'hFFFFC, 1'b0, '0, 1'b0);
    chk("R4 top rdata", last_rd, 32'hD00FFFFC);
  endtask

  task automatic t_disabled;
    int c2;
    win_en = 1'b0;
    c2 = nlog2;
    do_req(1'b0, 25'h1F12348, '0);
    chk("R3 count", 32'(nlog - b1), 32'd1);
    chk_entry("R3 entry", 0, 20'h12348, 1'b0, '0, 1'b0);
    chk("R3 rdata", last_rd, 32'hD0012348);
    chk("R3 forced instance count", 32'(nlog2 - c2), 32'd1);
    win_en = 1'b1;
  endtask

  task automatic t_mismatch;
    corrupt = 1'b1;
    do_req(1'b0, 25'h0100008, '0);
    chk("R8 err pulse", 32'(nerr - be), 32'd1);
    chk("R8 still accesses", 32'(nlog - b1), 32'd3);
    chk_entry("R8 data", 2, 20'h80008, 1'b0, '0, 1'b0);
    chk("R8 rdata", last_rd, 32'hD0080008);
    corrupt = 1'b0;
  endtask

  task automatic t_stall;
    stall = 1'b1;
    do_req(1'b1, 25'h0180004, 32'h5A5A_A5A5);
    chk("R10 count", 32'(nlog - b1), 32'd3);
    chk_entry("R10 sel", 0, SEL, 1'b1, 32'h4000_0003, 1'b1);
    chk_entry("R10 readback", 1, SEL, 1'b0, '0, 1'b0);
    chk_entry("R10 data", 2, 20'h80004, 1'b1, 32'h5A5A_A5A5, 1'b1);
    chk("R9 busy stalled", 32'(busy_seen), 32'd1);
    chk("R8 no err stalled", 32'(nerr - be), 32'd0);
    stall = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct_read();
    t_boundary_low();
    t_first_window();
    t_cached();
    t_top_window();
    t_disabled();
    t_mismatch();
    t_stall();
    chk("R8 forced instance no err", 32'(nerr2), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule